// File: doc/BRIEF.md
# Single-Bus Hardwired Instruction Sequencer

This block is a small processor core. It has a single internal bus and a hardwired controller driven by a step counter. A program counter, a memory address register, a memory data register, an instruction register, one accumulator, an ALU input latch and an ALU result latch all meet on one shared 16-bit bus. Each instruction is a fixed series of control steps. The controller decodes each step from the current step number, the opcode and the zero flag.

Every instruction starts with the same three-step fetch. The fetch increments the program counter through the shared adder by forcing the latched ALU input to zero and setting carry-in. An execute phase chosen by the opcode follows. Three instructions exist: accumulate a memory word, branch by a signed offset, and branch by a signed offset only when the zero flag is set. Memory sits outside the block behind a read request and a completion handshake. Any step that needs memory data stalls until the handshake arrives. A one-cycle completion pulse marks the last step of each instruction, so the observable state can be compared instruction by instruction.

Top module: `sbus_cpu`

## Requirements
- R1: Reset, asserted asynchronously at any time, sets PC to parameter RESET_PC, the accumulator to 0 and the zero flag to 1, and drives `mem_rd_o` and `instr_done_o` low. Internal release follows two clock edges after `rst_n` rises, and execution then begins with the first fetch step.
- R2: Fetch copies PC to `mem_addr_o` and raises `mem_rd_o`. `mem_rd_o` stays high, with `mem_addr_o` unchanged, until `mem_mfc_i` is seen. At the end of the fetch, PC equals the old PC plus 1, modulo 2^16.
- R3: While a step waits for memory, the step counter is frozen. Read data is captured in the cycle where `mem_mfc_i` is high. Each cycle without `mem_mfc_i` lengthens the instruction by one cycle.
- R4: Opcode 0001 (bits 15:12) adds the word at the zero-extended address in bits 11:0 to the accumulator, modulo 2^16. PC advances by 1. The instruction takes 8 cycles when every memory reply comes in its first cycle.
- R5: The zero flag is written only when the add instruction writes the accumulator, and it then equals (accumulator == 0).
- R6: Opcode 0010 sets PC to the incremented PC plus the sign-extended bits 11:0, leaves the accumulator unchanged, and takes 7 cycles.
- R7: Opcode 0011 with the zero flag set acts like opcode 0010 but takes 8 cycles.
- R8: Opcode 0011 with the zero flag clear ends in its fourth cycle with PC advanced by 1.
- R9: Any opcode other than 0001, 0010 or 0011 ends in its fourth cycle as a no-op, with PC advanced by 1.
- R10: `instr_done_o` is high for exactly one cycle, in the last step of each instruction. The next cycle is the first fetch step.
- R11: In every step, exactly one source drives the internal bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rd_o | output | 1 | Read request, held until completion |
| mem_addr_o | output | 16 | Memory address (address register) |
| mem_rdata_i | input | 16 | Read data, valid with completion |
| mem_mfc_i | input | 1 | Memory function complete |
| instr_done_o | output | 1 | One-cycle pulse in an instruction's final step |
| pc_o | output | 16 | Program counter |
| acc_o | output | 16 | Accumulator |
| zero_o | output | 1 | Zero flag |

## Verification
Some properties are checked on every cycle by assertions. These cover the single-source bus rule, the frozen step counter during a memory stall, the held read request with a steady address, the one-cycle completion pulse and the return to fetch after it. They also check that the accumulator changes only under the add opcode and that the zero flag follows each accumulator write. Other behaviour can only be shown by the bench's scenarios. That includes the arithmetic results, the branch targets built from sign-extended offsets, and the zero-extended operand address. It also includes the exact cycle count of each instruction type with and without memory stalls, and the recovery from a reset in the middle of an instruction.

// File: rtl/sbus_cpu_pkg.sv
package sbus_cpu_pkg;

  localparam int OPC_W = 4;
  localparam int NSRC  = 6;

  // bus source indices
  localparam int DRV_PC   = 0;
  localparam int DRV_Z    = 1;
  localparam int DRV_MDR  = 2;
  localparam int DRV_ACC  = 3;
  localparam int DRV_ADDR = 4;
  localparam int DRV_OFF  = 5;

  localparam logic [OPC_W-1:0] OP_ADD = 4'h1;
  localparam logic [OPC_W-1:0] OP_BR  = 4'h2;
  localparam logic [OPC_W-1:0] OP_BRZ = 4'h3;

  typedef struct packed {
    logic [NSRC-1:0] drv;
    logic            mar_ld;
    logic            pc_ld;
    logic            ir_ld;
    logic            acc_ld;
    logic            y_ld;
    logic            z_ld;
    logic            y_zero;
    logic            cin;
    logic            rd_start;
    logic            wait_mem;
    logic            done;
  } ctl_t;

endpackage

// File: rtl/sbus_cpu_alu.sv
module sbus_cpu_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o
);

  localparam int CW = W + 1;

  logic [CW-1:0] full;

  always_comb begin
    full  = {1'b0, a_i} + {1'b0, b_i} + {{(CW-1){1'b0}}, cin_i};
    sum_o = full[W-1:0];
  end

  logic unused_carry;
  assign unused_carry = full[CW-1];

endmodule

// File: rtl/sbus_cpu_ctrl.sv
module sbus_cpu_ctrl
  import sbus_cpu_pkg::*;
#(
  parameter int STEP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] op_i,
  input  logic             zero_i,
  input  logic             mfc_i,
  output ctl_t             ctl_o,
  output logic             rd_o,
  output logic             mdr_ld_o
);

  localparam logic [STEP_W-1:0] S1 = STEP_W'(1);
  localparam logic [STEP_W-1:0] S2 = STEP_W'(2);
  localparam logic [STEP_W-1:0] S3 = STEP_W'(3);
  localparam logic [STEP_W-1:0] S4 = STEP_W'(4);
  localparam logic [STEP_W-1:0] S5 = STEP_W'(5);
  localparam logic [STEP_W-1:0] S6 = STEP_W'(6);
  localparam logic [STEP_W-1:0] S7 = STEP_W'(7);

  logic [STEP_W-1:0] step_q, step_d;
  logic              rdp_q, rdp_d;
  logic              mfc_ok;
  ctl_t              c;

  assign mfc_ok = rdp_q & mfc_i;

  // control word decode
  always_comb begin
    c = '0;
    if (step_q == S1) begin
      c.drv[DRV_PC] = 1'b1;
      c.mar_ld      = 1'b1;
      c.rd_start    = 1'b1;
      c.y_zero      = 1'b1;
      c.cin         = 1'b1;
      c.z_ld        = 1'b1;
    end else if (step_q == S2) begin
      c.drv[DRV_Z]  = 1'b1;
      c.pc_ld       = 1'b1;
      c.wait_mem    = 1'b1;
    end else if (step_q == S3) begin
      c.drv[DRV_MDR] = 1'b1;
      c.ir_ld        = 1'b1;
    end else begin
      case (op_i)
        OP_ADD: begin
          if (step_q == S4) begin
            c.drv[DRV_ADDR] = 1'b1;
            c.mar_ld        = 1'b1;
            c.rd_start      = 1'b1;
          end else if (step_q == S5) begin
            c.drv[DRV_ACC] = 1'b1;
            c.y_ld         = 1'b1;
            c.wait_mem     = 1'b1;
          end else if (step_q == S6) begin
            c.drv[DRV_MDR] = 1'b1;
            c.z_ld         = 1'b1;
          end else if (step_q == S7) begin
            c.drv[DRV_Z] = 1'b1;
            c.acc_ld     = 1'b1;
          end else begin
            c.drv[DRV_PC] = 1'b1;
            c.done        = 1'b1;
          end
        end
        OP_BR: begin
          if (step_q == S4) begin
            c.drv[DRV_PC] = 1'b1;
            c.y_ld        = 1'b1;
          end else if (step_q == S5) begin
            c.drv[DRV_OFF] = 1'b1;
            c.z_ld         = 1'b1;
          end else if (step_q == S6) begin
            c.drv[DRV_Z] = 1'b1;
            c.pc_ld      = 1'b1;
          end else begin
            c.drv[DRV_PC] = 1'b1;
            c.done        = 1'b1;
          end
        end
        OP_BRZ: begin
          if (step_q == S4) begin
            c.drv[DRV_PC] = 1'b1;
            c.done        = ~zero_i;
          end else if (step_q == S5) begin
            c.drv[DRV_PC] = 1'b1;
            c.y_ld        = 1'b1;
          end else if (step_q == S6) begin
            c.drv[DRV_OFF] = 1'b1;
            c.z_ld         = 1'b1;
          end else if (step_q == S7) begin
            c.drv[DRV_Z] = 1'b1;
            c.pc_ld      = 1'b1;
          end else begin
            c.drv[DRV_PC] = 1'b1;
            c.done        = 1'b1;
          end
        end
        default: begin
          c.drv[DRV_PC] = 1'b1;
          c.done        = 1'b1;
        end
      endcase
    end
  end

  // next-state
  always_comb begin
    if (c.done)
      step_d = S1;
    else if (c.wait_mem && !mfc_ok)
      step_d = step_q;
    else
      step_d = step_q + S1;

    if (c.rd_start)
      rdp_d = 1'b1;
    else if (mfc_ok)
      rdp_d = 1'b0;
    else
      rdp_d = rdp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= S1;
      rdp_q  <= 1'b0;
    end else begin
      step_q <= step_d;
      rdp_q  <= rdp_d;
    end
  end

  assign ctl_o    = c;
  assign rd_o     = rdp_q;
  assign mdr_ld_o = mfc_ok;

  AST_WAIT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (c.wait_mem && !mfc_i) |=> $stable(step_q)); // R3
  AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rdp_q && !mfc_i) |=> rdp_q); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    c.done |=> !c.done); // R10
  AST_DONE_REFETCH: assert property (@(posedge clk) disable iff (!rst_n)
    c.done |=> (step_q == S1)); // R10

endmodule

// File: rtl/sbus_cpu_dp.sv
module sbus_cpu_dp
  import sbus_cpu_pkg::*;
#(
  parameter int              DATA_W   = 16,
  parameter int              FIELD_W  = 12,
  parameter logic [DATA_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl_i,
  input  logic              mdr_ld_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] mar_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              zero_o
);

  localparam int EXT_W = DATA_W - FIELD_W;

  logic [DATA_W-1:0] pc_q, mar_q, mdr_q, ir_q, acc_q, y_q, z_q;
  logic              zero_q;
  logic [DATA_W-1:0] bus, alu_a, alu_sum;
  logic [DATA_W-1:0] src [NSRC];

  assign src[DRV_PC]   = pc_q;
  assign src[DRV_Z]    = z_q;
  assign src[DRV_MDR]  = mdr_q;
  assign src[DRV_ACC]  = acc_q;
  assign src[DRV_ADDR] = {{EXT_W{1'b0}}, ir_q[FIELD_W-1:0]};
  assign src[DRV_OFF]  = {{EXT_W{ir_q[FIELD_W-1]}}, ir_q[FIELD_W-1:0]};

  // AND-OR single bus
  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (ctl_i.drv[i]) bus = bus | src[i];
    end
  end

  assign alu_a = ctl_i.y_zero ? '0 : y_q;

  sbus_cpu_alu #(.W(DATA_W)) u_alu (
    .a_i   (alu_a),
    .b_i   (bus),
    .cin_i (ctl_i.cin),
    .sum_o (alu_sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= RESET_PC;
      mar_q  <= '0;
      mdr_q  <= '0;
      ir_q   <= '0;
      acc_q  <= '0;
      y_q    <= '0;
      z_q    <= '0;
      zero_q <= 1'b1;
    end else begin
      if (ctl_i.pc_ld)  pc_q  <= bus;
      if (ctl_i.mar_ld) mar_q <= bus;
      if (mdr_ld_i)     mdr_q <= rdata_i;
      if (ctl_i.ir_ld)  ir_q  <= bus;
      if (ctl_i.y_ld)   y_q   <= bus;
      if (ctl_i.z_ld)   z_q   <= alu_sum;
      if (ctl_i.acc_ld) begin
        acc_q  <= bus;
        zero_q <= (bus == '0);
      end
    end
  end

  assign mar_o  = mar_q;
  assign ir_o   = ir_q;
  assign pc_o   = pc_q;
  assign acc_o  = acc_q;
  assign zero_o = zero_q;

  logic unused_ctl;
  assign unused_ctl = ^{ctl_i.rd_start, ctl_i.wait_mem, ctl_i.done};

  AST_ONE_BUS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(ctl_i.drv)); // R11
  AST_ZERO_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_i.acc_ld |=> (zero_q == (acc_q == '0))); // R5

endmodule

// File: rtl/sbus_cpu.sv
module sbus_cpu
  import sbus_cpu_pkg::*;
#(
  parameter int                DATA_W   = 16,
  parameter int                FIELD_W  = 12,
  parameter int                STEP_W   = 4,
  parameter logic [DATA_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_rd_o,
  output logic [DATA_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_mfc_i,
  output logic              instr_done_o,
  output logic [DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              zero_o
);

  localparam int OP_LO = DATA_W - OPC_W;

  logic              rst_q1, rst_q2;
  ctl_t              ctl;
  logic              mdr_ld;
  logic [DATA_W-1:0] ir;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  sbus_cpu_ctrl #(.STEP_W(STEP_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_q2),
    .op_i     (ir[DATA_W-1:OP_LO]),
    .zero_i   (zero_o),
    .mfc_i    (mem_mfc_i),
    .ctl_o    (ctl),
    .rd_o     (mem_rd_o),
    .mdr_ld_o (mdr_ld)
  );

  sbus_cpu_dp #(
    .DATA_W   (DATA_W),
    .FIELD_W  (FIELD_W),
    .RESET_PC (RESET_PC)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_q2),
    .ctl_i    (ctl),
    .mdr_ld_i (mdr_ld),
    .rdata_i  (mem_rdata_i),
    .mar_o    (mem_addr_o),
    .ir_o     (ir),
    .pc_o     (pc_o),
    .acc_o    (acc_o),
    .zero_o   (zero_o)
  );

  assign instr_done_o = ctl.done;

  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_q2)
    (mem_rd_o && !mem_mfc_i) |=> $stable(mem_addr_o)); // R2
  AST_ACC_ONLY_ADD: assert property (@(posedge clk) disable iff (!rst_q2)
    !$stable(acc_o) |-> ($past(ir[DATA_W-1:OP_LO]) == OP_ADD)); // R4

endmodule

// File: tb/tb_sbus_cpu.sv
module tb_sbus_cpu;

  localparam logic [15:0] START = 16'd1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic        mem_mfc = 1'b0;
  logic        done;
  logic [15:0] pc, acc;
  logic        zf;

  int n_chk = 0;
  int n_bad = 0;
  int wait_cyc = 0;
  int lat_cnt = 0;
  bit finished = 0;

  logic [15:0] mem [4096];

  always #5 clk = ~clk;

  sbus_cpu #(.RESET_PC(START)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_rd_o     (mem_rd),
    .mem_addr_o   (mem_addr),
    .mem_rdata_i  (mem_rdata),
    .mem_mfc_i    (mem_mfc),
    .instr_done_o (done),
    .pc_o         (pc),
    .acc_o        (acc),
    .zero_o       (zf)
  );

  // memory model: answers after wait_cyc extra cycles; upper address bits must be zero
  always @(negedge clk) begin
    if (mem_rd) begin
      if (lat_cnt == wait_cyc) begin
        mem_mfc   <= 1'b1;
        mem_rdata <= (mem_addr[15:12] == 4'h0) ? mem[mem_addr[11:0]] : 16'h0BAD;
        lat_cnt   <= 0;
      end else begin
        mem_mfc <= 1'b0;
        lat_cnt <= lat_cnt + 1;
      end
    end else begin
      mem_mfc <= 1'b0;
      lat_cnt <= 0;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_one(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!done);
  endtask

  // {pc, acc, zero, cycles (0 = not checked)}
  localparam int NV = 11;
  localparam logic [40:0] VEC [NV] = '{
    {16'd1001, 16'd30,    1'b0, 8'd0},  // R4 add
    {16'd1002, 16'd35,    1'b0, 8'd8},  // R4 add
    {16'd1003, 16'd35,    1'b0, 8'd4},  // R8 cond branch not taken
    {16'd1004, 16'h0000,  1'b1, 8'd8},  // R4 R5 wrap to zero
    {16'd1009, 16'h0000,  1'b1, 8'd8},  // R7 cond branch taken
    {16'd1007, 16'h0000,  1'b1, 8'd7},  // R6 negative offset
    {16'd1008, 16'h0000,  1'b1, 8'd4},  // R9 unknown opcode
    {16'd1009, 16'hFFFF,  1'b0, 8'd8},  // R4 zero-extended address
    {16'd1007, 16'hFFFF,  1'b0, 8'd7},  // R6
    {16'd1008, 16'hFFFF,  1'b0, 8'd4},  // R9
    {16'd1009, 16'hFFFE,  1'b0, 8'd8}   // R4 R5
  };

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cyc;
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    mem[1000] = 16'h15DC;  // add [1500]
    mem[1001] = 16'h15DD;  // add [1501]
    mem[1002] = 16'h300A;  // brz +10
    mem[1003] = 16'h15DE;  // add [1502]
    mem[1004] = 16'h3004;  // brz +4
    mem[1007] = 16'hF123;  // unknown
    mem[1008] = 16'h1A00;  // add [0xA00]
    mem[1009] = 16'h2FFD;  // br -3
    mem[1500] = 16'd30;
    mem[1501] = 16'd5;
    mem[1502] = 16'hFFDD;
    mem[12'hA00] = 16'hFFFF;

    repeat (3) @(negedge clk);
    chk("R1 pc", pc, START);
    chk("R1 acc", acc, 16'h0);
    chk("R1 zero", {15'b0, zf}, 16'h1);
    chk("R1 rd", {15'b0, mem_rd}, 16'h0);
    chk("R1 done", {15'b0, done}, 16'h0);
    @(posedge clk); #1 rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      run_one(cyc);
      chk("R4/R6/R7/R8/R9 pc", pc, VEC[v][40:25]);
      chk("R4/R5 acc", acc, VEC[v][24:9]);
      chk("R5 zero", {15'b0, zf}, {15'b0, VEC[v][8]});
      if (VEC[v][7:0] != 8'd0)
        chk("R2/R10 cycles", 16'(cyc), {8'd0, VEC[v][7:0]});
    end

    // R3: memory stalls of two cycles per access
    wait_cyc = 2;
    run_one(cyc);
    chk("R3 R6 pc", pc, 16'd1007);
    chk("R3 branch cycles", 16'(cyc), 16'd9);
    run_one(cyc);
    chk("R3 R9 pc", pc, 16'd1008);
    chk("R3 no-op cycles", 16'(cyc), 16'd6);
    run_one(cyc);
    chk("R3 R4 acc", acc, 16'hFFFD);
    chk("R3 add cycles", 16'(cyc), 16'd12);
    chk("R3 R2 pc", pc, 16'd1009);

    // R10: done lasts one cycle
    @(negedge clk);
    chk("R10 pulse width", {15'b0, done}, 16'h0);

    // R1: reset mid-instruction
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 mid pc", pc, START);
    chk("R1 mid acc", acc, 16'h0);
    chk("R1 mid zero", {15'b0, zf}, 16'h1);
    chk("R1 mid rd", {15'b0, mem_rd}, 16'h0);
    wait_cyc = 0;
    repeat (2) @(negedge clk);
    @(posedge clk); #1 rst_n = 1'b1;
    run_one(cyc);
    chk("R1 R4 restart acc", acc, 16'd30);
    chk("R1 R2 restart pc", pc, 16'd1001);
    run_one(cyc);
    chk("R10 restart cycles", 16'(cyc), 16'd8);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule